// File: doc/BRIEF.md
# HDLC Receive Byte Queue with Packet Tags

This block buffers the bytes that an HDLC deframer recovers from the line until a host can collect them. The deframer pushes each byte with three markers: opening byte, closing byte, and frame-check-good. The block stores the byte and its tags as one entry. The host sees the oldest entry at all times and pops one byte at a time. Each byte comes with its own status: queue empty, opening-byte, closing-byte, and packet-good. The packet-good verdict is kept only on the closing byte. The host uses it to accept or discard the whole packet it has gathered.

Alongside the data path, the block keeps four latched receive events: packet opened, packet closed, queue holds data, and queue at least half full. It also keeps an overrun flag for bytes that arrived while the queue was full. A per-event enable vector selects which events pull the active-low interrupt line. One status-read strobe returns the latched events to the host and clears them. Flag hunting, bit destuffing, the CRC engine and the host bus decode live outside this block.

Top module: `hdlc_rx_fifo`

## Requirements
- R1: After reset the queue is empty: `rd_empty`=1, `rd_data`, `rd_first`, `rd_last` and `rd_good` are 0, `ev_stat`=0, `ovr_flag`=0 and `irq_n`=1.
- R2: While the queue is not empty, the outputs show the oldest stored byte together with its opening-byte and closing-byte tags. A pop removes it, and bytes leave in the order they were pushed.
- R3: `rd_good` shows the frame-check verdict pushed with a closing byte (1 = accept, 0 = discard). It is 0 on every byte whose closing-byte tag is 0.
- R4: While `rd_empty`=1, all head outputs read 0. A pop in that state changes nothing, so the next pushed byte is the next one returned.
- R5: A push while the queue holds DEPTH (default 64) entries is dropped and sets `ovr_flag`. The flag stays set until a status read, which clears it.
- R6: Event bit 0 sets on the clock edge that accepts a byte tagged opening. Event bit 1 sets on the edge that accepts a byte tagged closing.
- R7: Event bit 2 is a level event: it is set on each edge while the queue holds at least one entry. Event bit 3 is set on each edge while the queue holds at least DEPTH/2 entries.
- R8: `irq_n` is 0 exactly when some latched event bit has its `ev_en` bit at 1. Bits with `ev_en` at 0 never pull it low.
- R9: A status read (`stat_rd`=1) returns `ev_stat` and clears all latched bits on that edge. Packet events that arrive on the same edge stay set. A level event whose condition still holds sets again on the following edge.
- R10: The interrupt returns high after a status read only if no other enabled event is still latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Deframer pushes a byte |
| wr_data | input | 8 | Received byte |
| wr_sop | input | 1 | Byte opens a packet |
| wr_eop | input | 1 | Byte closes a packet |
| wr_good | input | 1 | Frame check passed (used with wr_eop) |
| rd_pop | input | 1 | Host pops the head byte |
| rd_data | output | 8 | Head byte, 0 when empty |
| rd_empty | output | 1 | No byte available |
| rd_first | output | 1 | Head byte opens a packet |
| rd_last | output | 1 | Head byte closes a packet |
| rd_good | output | 1 | Packet verdict on a closing byte |
| ev_en | input | 4 | Interrupt enable per event (1 = enabled) |
| stat_rd | input | 1 | Host reads and clears the event status |
| ev_stat | output | 4 | Latched events: 0 opened, 1 closed, 2 has data, 3 half full |
| ovr_flag | output | 1 | A push was dropped while full |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The queue is exercised with a good packet and with a bad packet. These separate correct tag storage from a verdict that leaks onto non-closing bytes or is stuck at one value. A linear ramp filled to the brim and then pushed one byte past full shows where the half-full threshold sits, shows that the excess byte is discarded and not written over the oldest entry, and shows that the order holds across pointer wrap. Pops on an empty queue followed by a single push separate a pointer that wrongly advances from one that holds. Status reads with the enable vector changed around them separate masking, clear-on-read and the re-arming of level events from one another.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam int BYTE_W = 8;
  localparam int EV_W   = 4;

  // event bit positions, host software decodes these
  localparam int EV_OPEN  = 0;
  localparam int EV_CLOSE = 1;
  localparam int EV_DATA  = 2;
  localparam int EV_HALF  = 3;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              first;
    logic              last;
    logic              good;
  } rx_entry_t;

endpackage

// File: rtl/hdlc_rx_store.sv
module hdlc_rx_store
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  rx_entry_t                 push_ent,
  input  logic                      pop,
  output rx_entry_t                 head,
  output logic                      empty,
  output logic                      full,
  output logic [$clog2(DEPTH):0]    fill
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  // occupancy from wrap-extended pointers
  function automatic logic [PW-1:0] occupancy(input logic [PW-1:0] w,
                                              input logic [PW-1:0] r);
    return w - r;
  endfunction

  rx_entry_t       mem [DEPTH];
  logic [PW-1:0]   wp, rp;
  logic            push_ok, pop_ok;

  assign fill    = occupancy(wp, rp);
  assign empty   = (fill == '0);
  assign full    = (fill == PW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = empty ? '0 : mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp[AW-1:0]] <= push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
    end
  end

endmodule

// File: rtl/hdlc_rx_events.sv
module hdlc_rx_events
  import hdlc_rx_pkg::*;
#(
  parameter logic [EV_W-1:0] LEVEL_KIND = 4'b1100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EV_W-1:0]  ev_set,
  input  logic             ovr_set,
  input  logic             rd_clr,
  input  logic [EV_W-1:0]  ev_en,
  output logic [EV_W-1:0]  ev_q,
  output logic             ovr_q,
  output logic             irq_n
);

  // level kinds are held off for the read edge so they re-arm one edge later
  for (genvar i = 0; i < EV_W; i++) begin : g_ev
    if (LEVEL_KIND[i]) begin : g_level
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ev_q[i] <= 1'b0;
        else if (rd_clr) ev_q[i] <= 1'b0;
        else             ev_q[i] <= ev_q[i] | ev_set[i];
      end
    end else begin : g_pulse
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ev_q[i] <= 1'b0;
        else if (rd_clr) ev_q[i] <= ev_set[i];
        else             ev_q[i] <= ev_q[i] | ev_set[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovr_q <= 1'b0;
    else if (rd_clr) ovr_q <= ovr_set;
    else             ovr_q <= ovr_q | ovr_set;
  end

  assign irq_n = ~|(ev_q & ev_en);

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        wr_sop,
  input  logic        wr_eop,
  input  logic        wr_good,
  input  logic        rd_pop,
  output logic [7:0]  rd_data,
  output logic        rd_empty,
  output logic        rd_first,
  output logic        rd_last,
  output logic        rd_good,
  input  logic [3:0]  ev_en,
  input  logic        stat_rd,
  output logic [3:0]  ev_stat,
  output logic        ovr_flag,
  output logic        irq_n
);

  localparam int CW = $clog2(DEPTH) + 1;

  function automatic logic at_half(input logic [CW-1:0] n);
    return n >= CW'(DEPTH / 2);
  endfunction

  rx_entry_t        in_ent, head_ent;
  logic             q_full;
  logic [CW-1:0]    fill_cnt;
  logic             push_acc;     // byte accepted into the queue
  logic             push_drop;    // byte lost to a full queue
  logic [EV_W-1:0]  ev_raise;

  assign in_ent.data  = wr_data;
  assign in_ent.first = wr_sop;
  assign in_ent.last  = wr_eop;
  assign in_ent.good  = wr_good & wr_eop;

  assign push_acc  = wr_en && !q_full;
  assign push_drop = wr_en && q_full;

  hdlc_rx_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (wr_en),
    .push_ent (in_ent),
    .pop      (rd_pop),
    .head     (head_ent),
    .empty    (rd_empty),
    .full     (q_full),
    .fill     (fill_cnt)
  );

  assign ev_raise[EV_OPEN]  = push_acc & wr_sop;
  assign ev_raise[EV_CLOSE] = push_acc & wr_eop;
  assign ev_raise[EV_DATA]  = !rd_empty;
  assign ev_raise[EV_HALF]  = at_half(fill_cnt);

  hdlc_rx_events u_events (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_set  (ev_raise),
    .ovr_set (push_drop),
    .rd_clr  (stat_rd),
    .ev_en   (ev_en),
    .ev_q    (ev_stat),
    .ovr_q   (ovr_flag),
    .irq_n   (irq_n)
  );

  assign rd_data  = head_ent.data;
  assign rd_first = head_ent.first;
  assign rd_last  = head_ent.last;
  assign rd_good  = head_ent.good;

endmodule

// File: rtl/hdlc_rx_fifo_chk.sv
module hdlc_rx_fifo_chk #(
  parameter int DEPTH = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic                    wr_sop,
  input logic                    wr_eop,
  input logic                    rd_pop,
  input logic                    stat_rd,
  input logic                    rd_empty,
  input logic [7:0]              rd_data,
  input logic                    rd_first,
  input logic                    rd_last,
  input logic                    rd_good,
  input logic                    q_full,
  input logic [$clog2(DEPTH):0]  fill_cnt,
  input logic [3:0]              ev_en,
  input logic [3:0]              ev_stat,
  input logic                    ovr_flag,
  input logic                    irq_n
);

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= ($clog2(DEPTH)+1)'(DEPTH));

  a_r5_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && q_full && !rd_pop) |=> ovr_flag);

  a_r4_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_empty && rd_pop && !wr_en) |=> rd_empty);

  a_r4_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_empty |-> (rd_data == 8'h00 && !rd_first && !rd_last && !rd_good));

  a_r3_good_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    rd_good |-> rd_last);

  a_r6_open_event: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sop && !q_full) |=> ev_stat[0]);

  a_r6_close_event: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_eop && !q_full) |=> ev_stat[1]);

  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_en == 4'b0000) |-> irq_n);

  a_r9_read_clears_level: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (!ev_stat[2] && !ev_stat[3]));

  a_r7_data_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_empty && !stat_rd) |=> ev_stat[2]);

endmodule

bind hdlc_rx_fifo hdlc_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_sop   (wr_sop),
  .wr_eop   (wr_eop),
  .rd_pop   (rd_pop),
  .stat_rd  (stat_rd),
  .rd_empty (rd_empty),
  .rd_data  (rd_data),
  .rd_first (rd_first),
  .rd_last  (rd_last),
  .rd_good  (rd_good),
  .q_full   (q_full),
  .fill_cnt (fill_cnt),
  .ev_en    (ev_en),
  .ev_stat  (ev_stat),
  .ovr_flag (ovr_flag),
  .irq_n    (irq_n)
);

// File: tb/hdlc_rx_fifo_tb.sv
module hdlc_rx_fifo_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0, wr_good = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_pop = 1'b0, stat_rd = 1'b0;
  logic [3:0] ev_en = 4'b0000;
  logic [7:0] rd_data;
  logic       rd_empty, rd_first, rd_last, rd_good;
  logic [3:0] ev_stat;
  logic       ovr_flag, irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_good(wr_good),
    .rd_pop(rd_pop), .rd_data(rd_data), .rd_empty(rd_empty), .rd_first(rd_first),
    .rd_last(rd_last), .rd_good(rd_good), .ev_en(ev_en), .stat_rd(stat_rd),
    .ev_stat(ev_stat), .ovr_flag(ovr_flag), .irq_n(irq_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic push(input logic [7:0] d, input logic s, input logic e, input logic g);
    wr_en = 1'b1; wr_data = d; wr_sop = s; wr_eop = e; wr_good = g;
    @(negedge clk);
    wr_en = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0; wr_good = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [7:0] d,
                            input logic f, input logic l, input logic g);
    check(!rd_empty, req, rd_empty, 0);
    check(rd_data == d, req, rd_data, d);
    check({rd_first, rd_last, rd_good} == {f, l, g}, req,
          {rd_first, rd_last, rd_good}, {f, l, g});
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic read_status(output logic [3:0] seen);
    seen = ev_stat;
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check(rd_empty == 1'b1, "R1 empty", rd_empty, 1);
    check({rd_data, rd_first, rd_last, rd_good} == 11'd0, "R1 head", rd_data, 0);
    check(ev_stat == 4'd0, "R1 events", ev_stat, 0);
    check(ovr_flag == 1'b0 && irq_n == 1'b1, "R1 ovr/irq", {ovr_flag, irq_n}, 1);
  endtask

  task automatic t_empty_pop;
    logic [3:0] s;
    rd_pop = 1'b1;
    idle(3);
    rd_pop = 1'b0;
    check(rd_empty && rd_data == 8'h00, "R4 empty pop zeros", rd_data, 0);
    push(8'h5A, 1'b1, 1'b1, 1'b1);
    pop_expect("R4 pointer held", 8'h5A, 1'b1, 1'b1, 1'b1);
    check(rd_empty, "R4 empty again", rd_empty, 1);
    read_status(s);
  endtask

  task automatic t_mask_and_clear;
    logic [3:0] s;
    ev_en = 4'b0000;
    push(8'h11, 1'b1, 1'b0, 1'b0);
    push(8'h22, 1'b0, 1'b1, 1'b1);
    idle(1);
    check(ev_stat == 4'b0111, "R6 R7 events latched", ev_stat, 4'b0111);
    check(irq_n == 1'b1, "R8 all masked", irq_n, 1);
    ev_en = 4'b0001;
    #1;
    check(irq_n == 1'b0, "R8 open enabled", irq_n, 0);
    @(negedge clk);
    read_status(s);
    check(s == 4'b0111, "R9 read value", s, 4'b0111);
    check(ev_stat == 4'b0000, "R9 cleared", ev_stat, 0);
    check(irq_n == 1'b1, "R10 released", irq_n, 1);
    @(negedge clk);
    check(ev_stat == 4'b0100, "R9 level rearm", ev_stat, 4'b0100);
    check(irq_n == 1'b1, "R8 data masked", irq_n, 1);
    ev_en = 4'b0101;
    #1;
    check(irq_n == 1'b0, "R10 other pending", irq_n, 0);
    @(negedge clk);
    ev_en = 4'b0000;
    pop_expect("R2 first byte", 8'h11, 1'b1, 1'b0, 1'b0);
    pop_expect("R2 R3 closing good", 8'h22, 1'b0, 1'b1, 1'b1);
    read_status(s);
  endtask

  task automatic t_bad_packet;
    logic [3:0] s;
    push(8'hA0, 1'b1, 1'b0, 1'b1);
    push(8'hA1, 1'b0, 1'b0, 1'b1);
    push(8'hA2, 1'b0, 1'b1, 1'b0);
    pop_expect("R3 no verdict on opening", 8'hA0, 1'b1, 1'b0, 1'b0);
    pop_expect("R3 no verdict mid", 8'hA1, 1'b0, 1'b0, 1'b0);
    pop_expect("R3 discard verdict", 8'hA2, 1'b0, 1'b1, 1'b0);
    read_status(s);
  endtask

  task automatic t_fill_overrun;
    logic [3:0] s;
    for (int i = 0; i < DEPTH/2 - 1; i++) push(8'(i), 1'b0, 1'b0, 1'b0);
    read_status(s);
    @(negedge clk);
    check(ev_stat[3] == 1'b0, "R7 below half", ev_stat, 0);
    push(8'(DEPTH/2 - 1), 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check(ev_stat[3] == 1'b1, "R7 half reached", ev_stat, 4'b1000);
    for (int i = DEPTH/2; i < DEPTH; i++) push(8'(i), 1'b0, 1'b0, 1'b0);
    check(ovr_flag == 1'b0, "R5 no overrun at full", ovr_flag, 0);
    push(8'hEE, 1'b1, 1'b1, 1'b1);
    check(ovr_flag == 1'b1, "R5 overrun set", ovr_flag, 1);
    idle(2);
    check(ovr_flag == 1'b1, "R5 overrun held", ovr_flag, 1);
    read_status(s);
    check(ovr_flag == 1'b0, "R5 overrun cleared", ovr_flag, 0);
    for (int i = 0; i < DEPTH; i++)
      pop_expect("R2 R5 order kept", 8'(i), 1'b0, 1'b0, 1'b0);
    check(rd_empty == 1'b1, "R5 dropped byte absent", rd_empty, 1);
    // order across pointer wrap
    push(8'h77, 1'b1, 1'b1, 1'b1);
    pop_expect("R2 after wrap", 8'h77, 1'b1, 1'b1, 1'b1);
    read_status(s);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty_pop();
    t_mask_and_clear();
    t_bad_packet();
    t_fill_overrun();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule